// File: doc/BRIEF.md
# Trigger Event Counter with Alternating Board Selector

This block follows the stream of level-1 trigger accepts reaching a readout board. A local 32-bit counter advances once per accept. An event-counter-reset strobe sets the counter to all ones, so the next accept reads zero. The active-low asynchronous reset clears the counter to zero.

On each accept strobe the block also decides whether this board should read the event out. The decision uses bit 0 of the 24-bit level-1 identifier, a two-bit mode select and a slot-identity bit. Two boards can therefore share the events between them, taking odd and even identifiers in turn. One board can take every event when it is the only one fitted, or a board can take none while it is being debugged. The decision is held in a register and stays unchanged until the next accept strobe.

Top module: `trig_evt_sel`

## Requirements
- R1: After the asynchronous reset (rst_ni low), evt_count_o is 0 and take_evt_o is 0.
- R2: Each cycle with l1a_i high and ecr_i low raises evt_count_o by one on the following clock edge. In all other cycles the count holds, except when ecr_i is high.
- R3: A cycle with ecr_i high loads evt_count_o with 32'hFFFF_FFFF on the next edge, and the following accept brings it to 0.
- R4: When ecr_i and l1a_i are high in the same cycle, the reset wins and the count becomes 32'hFFFF_FFFF.
- R5: The count wraps from 32'hFFFF_FFFF to 0 on an accept and raises no flag.
- R6: With mode_i = 2'b00, an accept sets take_evt_o on the next edge to (slot_i == l1id_i[0]).
- R7: With mode_i = 2'b01, an accept sets take_evt_o on the next edge to (slot_i != l1id_i[0]).
- R8: With mode_i = 2'b10, an accept clears take_evt_o whatever slot_i and l1id_i are. With mode_i = 2'b11, an accept sets it whatever they are.
- R9: take_evt_o changes only on the edge after an accept strobe, and it uses the identifier, mode and slot values present during that strobe. Bits 23:1 of l1id_i have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1a_i | input | 1 | Level-1 accept strobe |
| ecr_i | input | 1 | Event-counter-reset strobe |
| l1id_i | input | 24 | Level-1 event identifier |
| mode_i | input | 2 | Selector mode: 00 match, 01 inverted, 10 none, 11 all |
| slot_i | input | 1 | Slot identity, 1 for logical slot 1 and 0 for logical slot 2 |
| evt_count_o | output | 32 | Event counter |
| take_evt_o | output | 1 | Registered accept-enable for the last strobe |

## Verification
The assertions check the counter's step rules on every cycle: an increment on an accept, the all-ones load on a reset (including when both strobes arrive together), and no change when neither strobe is present. They also check that the accept-enable holds between strobes and follows the four modes after each strobe. The bench scenarios are needed for the rest: the value after reset, the wrap from all ones to zero reached by a counter reset followed by an accept, and the upper identifier bits having no effect. Long random runs compare both outputs against a model.

// File: rtl/trig_evt_pkg.sv
package trig_evt_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned L1ID_W = 24;

  typedef enum logic [1:0] {
    SEL_MATCH  = 2'b00,
    SEL_INVERT = 2'b01,
    SEL_NONE   = 2'b10,
    SEL_ALL    = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/trig_evt_counter.sv
module trig_evt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         l1a_i,
  input  logic         ecr_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ecr_i) cnt_q <= '1;       // reset beats accept
    else if (l1a_i) cnt_q <= cnt_q + 1'b1;  // free wrap
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/trig_evt_decide.sv
module trig_evt_decide
  import trig_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      l1a_i,
  input  logic      id_lsb_i,
  input  sel_mode_e mode_i,
  input  logic      slot_i,
  output logic      take_o
);
  logic take_d, take_q;

  always_comb begin
    unique case (mode_i)
      SEL_MATCH:  take_d = (slot_i == id_lsb_i);
      SEL_INVERT: take_d = (slot_i != id_lsb_i);
      SEL_NONE:   take_d = 1'b0;
      default:    take_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    take_q <= 1'b0;
    else if (l1a_i) take_q <= take_d;
  end

  assign take_o = take_q;
endmodule

// File: rtl/trig_evt_sel.sv
module trig_evt_sel
  import trig_evt_pkg::*;
#(
  parameter int unsigned CNT_W_P  = CNT_W,
  parameter int unsigned L1ID_W_P = L1ID_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                l1a_i,
  input  logic                ecr_i,
  input  logic [L1ID_W_P-1:0] l1id_i,
  input  logic [1:0]          mode_i,
  input  logic                slot_i,
  output logic [CNT_W_P-1:0]  evt_count_o,
  output logic                take_evt_o
);
  sel_mode_e mode;
  assign mode = sel_mode_e'(mode_i);

  trig_evt_counter #(.W(CNT_W_P)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .l1a_i   (l1a_i),
    .ecr_i   (ecr_i),
    .count_o (evt_count_o)
  );

  trig_evt_decide u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .l1a_i    (l1a_i),
    .id_lsb_i (l1id_i[0]),
    .mode_i   (mode),
    .slot_i   (slot_i),
    .take_o   (take_evt_o)
  );
endmodule

// File: rtl/trig_evt_sel_chk.sv
module trig_evt_sel_chk #(
  parameter int unsigned CNT_W_P  = 32,
  parameter int unsigned L1ID_W_P = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                l1a_i,
  input logic                ecr_i,
  input logic [L1ID_W_P-1:0] l1id_i,
  input logic [1:0]          mode_i,
  input logic                slot_i,
  input logic [CNT_W_P-1:0]  evt_count_o,
  input logic                take_evt_o
);
  // R2
  inc_on_l1a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && !ecr_i) |=> evt_count_o == $past(evt_count_o) + 1'b1);
  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l1a_i && !ecr_i) |=> $stable(evt_count_o));
  // R3 R4
  ecr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecr_i |=> &evt_count_o);
  // R9
  take_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l1a_i |=> $stable(take_evt_o));
  // R6
  mode_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && mode_i == 2'b00) |=> take_evt_o == $past(slot_i == l1id_i[0]));
  // R7
  mode_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && mode_i == 2'b01) |=> take_evt_o == $past(slot_i != l1id_i[0]));
  // R8
  mode_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && mode_i == 2'b10) |=> !take_evt_o);
  // R8
  mode_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && mode_i == 2'b11) |=> take_evt_o);
endmodule

bind trig_evt_sel trig_evt_sel_chk #(.CNT_W_P(CNT_W_P), .L1ID_W_P(L1ID_W_P)) u_chk (.*);

// File: tb/tb_trig_evt_sel.sv
`timescale 1ns/1ps
module tb_trig_evt_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        l1a = 1'b0, ecr = 1'b0, slot = 1'b0;
  logic [23:0] l1id = '0;
  logic [1:0]  mode = '0;
  logic [31:0] cnt;
  logic        take;
  int checks = 0, errors = 0;
  logic [31:0] exp_cnt;
  logic        exp_take;
  bit          done = 0;

  always #2.5 clk = ~clk;

  trig_evt_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .l1a_i(l1a), .ecr_i(ecr), .l1id_i(l1id),
    .mode_i(mode), .slot_i(slot), .evt_count_o(cnt), .take_evt_o(take)
  );

  function automatic logic model_take(logic [1:0] m, logic s, logic b);
    case (m)
      2'b00: return s == b;
      2'b01: return s != b;
      2'b10: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk_cnt(string r, logic [31:0] e);
    checks++;
    if (cnt !== e) begin errors++; $display("FAIL %s count act=%h exp=%h", r, cnt, e); end
  endtask

  task automatic chk_take(string r, logic e);
    checks++;
    if (take !== e) begin errors++; $display("FAIL %s take act=%b exp=%b", r, take, e); end
  endtask

  // drive at negedge, update model, sample at next negedge
  task automatic step(logic a, logic c, logic [23:0] id, logic [1:0] m, logic s);
    l1a = a; ecr = c; l1id = id; mode = m; slot = s;
    if (c) exp_cnt = '1; else if (a) exp_cnt = exp_cnt + 1;
    if (a) exp_take = model_take(m, s, id[0]);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_cnt = 0; exp_take = 0;
    @(negedge clk); @(negedge clk);
    chk_cnt("R1", 0); chk_take("R1", 0);
    rst_ni = 1'b1; @(negedge clk);

    step(1, 0, 24'h0, 2'b11, 0); chk_cnt("R2", exp_cnt); chk_take("R8", 1);
    step(0, 0, 24'h1, 2'b10, 0); chk_cnt("R2", 1); chk_take("R9", 1);
    step(1, 0, 24'h1, 2'b10, 1); chk_take("R8", 0);
    step(0, 0, 24'h1, 2'b11, 1); chk_take("R9", 0);
    // R6 each slot/lsb combination, high bits toggled (R9)
    for (int i = 0; i < 4; i++) begin
      step(1, 0, {23'h7FFFFF * i[0], i[0]}, 2'b00, i[1]);
      chk_take("R6", i[1] == i[0]);
    end
    for (int i = 0; i < 4; i++) begin
      step(1, 0, {23'h2AAAAA, i[0]}, 2'b01, i[1]);
      chk_take("R7", i[1] != i[0]);
    end
    step(1, 0, 24'hFFFFFE, 2'b00, 0); chk_take("R9", 1);
    step(1, 0, 24'h000000, 2'b00, 0); chk_take("R9", 1);
    step(0, 1, 24'h0, 2'b00, 0); chk_cnt("R3", 32'hFFFF_FFFF);
    step(1, 0, 24'h0, 2'b00, 0); chk_cnt("R5", 0);
    step(0, 1, 24'h0, 2'b00, 0);
    step(0, 0, 24'h0, 2'b00, 0); chk_cnt("R3", 32'hFFFF_FFFF);
    step(1, 1, 24'h1, 2'b11, 0); chk_cnt("R4", 32'hFFFF_FFFF); chk_take("R8", 1);
    step(1, 0, 24'h1, 2'b00, 0); chk_cnt("R5", 0);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[7:2] == 0, 24'($urandom), r[9:8], r[10]);
      chk_cnt("R2", exp_cnt); chk_take("R9", exp_take);
    end

    rst_ni = 1'b0; #1;
    chk_cnt("R1", 0); chk_take("R1", 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule